// File: doc/BRIEF.md
# Edge-Qualified Timer/Counter Core

This block is a free-running 16-bit up-counter. A small control register decides what makes it advance. In timer mode it steps on every clock. In the three counter modes it steps only when a chosen kind of transition (rising, falling, or either) appears on one of several capture inputs. The capture inputs may be asynchronous. Each lane passes through a two-flop synchronizer. The selected lane is then compared with its previous sample once per clock, and that pair is classified as a rise, a fall or no change.

Software writes the control word through a simple write strobe and reads it back at any time. An enable freezes the count without losing edge history. A synchronous clear returns the count to zero and drops any edge that is pending in that cycle. When the selected lane changes, the history is reloaded from the new lane, so the switch does not look like a transition.

Top module: `edge_qual_timer`

## Requirements
- R1: After the asynchronous reset `rstN` is released, `count` is 0 and `cfgRdData` is 0 (timer mode, lane 0).
- R2: A clock edge with `cfgWrEn` high stores `cfgWrData` into the control word, and `cfgRdData` shows it after that edge. Bits 1:0 hold the edge mode and bits 3:2 hold the capture lane index.
- R3: With edge mode 00 (timer) and `cntEn` high, `count` rises by one on every clock edge.
- R4: With edge mode 01, `count` rises by one for each 0-to-1 change of the selected lane. The increment is visible after the third clock edge that follows the input change.
- R5: With edge mode 10, `count` rises by one for each 1-to-0 change of the selected lane, with the same three-edge latency.
- R6: With edge mode 11, `count` rises by one for every change of the selected lane, with the same three-edge latency.
- R7: Changes on capture lanes other than the selected one leave `count` unchanged.
- R8: While `cntEn` is low and `cntClr` is low, `count` holds. An edge seen while disabled is not counted after `cntEn` returns high.
- R9: `cntClr` high at a clock edge sets `count` to 0 regardless of `cntEn`. An edge pending at that same edge is discarded.
- R10: The count wraps from 0xFFFF to 0x0000 on the next increment.
- R11: Writing a new lane index does not by itself produce a count, even when the old and new lanes sit at different levels.
- R12: Apart from a clear, `count` changes by at most +1 per clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 4 | Control word: [1:0] edge mode, [3:2] lane index |
| cfgRdData | output | 4 | Current control word |
| cntEn | input | 1 | Counting enable |
| cntClr | input | 1 | Synchronous clear of the count |
| capIn | input | 4 | Asynchronous capture lanes |
| count | output | 16 | Current count value |

## Verification
A change on a capture lane reaches `count` after exactly three rising edges: two for the synchronizer and one for the counter. Timer-mode increments, clears and control writes take effect after a single edge. The bench changes inputs on the falling edge. It then waits the exact number of falling edges that span the required rising edges before it compares `count` against a value derived from how many rises and falls it has applied. Each lane-and-mode combination is swept with alternating toggles of the selected and unselected lanes. The count is checked after every toggle, so a one-cycle latency error or a missed edge shows up at once.

// File: rtl/eqt_pkg.sv
package eqt_pkg;

  // Edge mode field, control word bits [1:0]
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } cntMode_e;

  // Classification of a pair of consecutive lane samples
  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_RISE = 2'b01,
    EV_FALL = 2'b10
  } sampEvent_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic incr;    // advance the count
    logic clr;     // zero the count
    logic reload;  // reload history from the newly chosen lane
  } cntStrobe_t;

  function automatic sampEvent_e classifyPair(input logic prevLvl, input logic currLvl);
    sampEvent_e ev;
    ev = EV_NONE;
    if (currLvl && !prevLvl) ev = EV_RISE;
    else if (!currLvl && prevLvl) ev = EV_FALL;
    return ev;
  endfunction

endpackage

// File: rtl/eqt_sync2.sv
module eqt_sync2 (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/eqt_datapath.sv
module eqt_datapath
  import eqt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CAP = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CAP-1:0] capIn,
  input  logic [SEL_W-1:0]   curSel,
  input  logic [SEL_W-1:0]   reloadSel,
  input  cntStrobe_t         strobe,
  output logic [CNT_W-1:0]   count,
  output logic               sampCurr,
  output logic               sampPrev
);
  localparam int LANES = 1 << SEL_W;

  // Lanes padded to a power of two; unused lanes read as 0
  logic [LANES-1:0] laneLvl;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    if (gi < NUM_CAP) begin : g_real
      eqt_sync2 u_sync (
        .clk    (clk),
        .rstN   (rstN),
        .asyncIn(capIn[gi]),
        .syncOut(laneLvl[gi])
      );
    end else begin : g_pad
      assign laneLvl[gi] = 1'b0;
    end
  end

  assign sampCurr = laneLvl[curSel];

  // Previous sample of the selected lane
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampPrev <= 1'b0;
    end else if (strobe.reload) begin
      sampPrev <= laneLvl[reloadSel];
    end else begin
      sampPrev <= sampCurr;
    end
  end

  // Count register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clr) begin
      count <= '0;
    end else if (strobe.incr) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/eqt_ctrl.sv
module eqt_ctrl
  import eqt_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [SEL_W+1:0] cfgWrData,
  input  logic             cntEn,
  input  logic             cntClr,
  input  logic             sampCurr,
  input  logic             sampPrev,
  output logic [SEL_W+1:0] cfgQ,
  output logic [SEL_W-1:0] curSel,
  output logic [SEL_W-1:0] reloadSel,
  output cntStrobe_t       strobe
);
  localparam int CFG_W = SEL_W + 2;

  logic [CFG_W-1:0] cfgReg;
  cntMode_e         modeNow;
  sampEvent_e       evNow;
  logic             hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgWrEn) begin
      cfgReg <= cfgWrData;
    end
  end

  assign cfgQ      = cfgReg;
  assign curSel    = cfgReg[CFG_W-1:2];
  assign reloadSel = cfgWrData[CFG_W-1:2];
  assign modeNow   = cntMode_e'(cfgReg[1:0]);
  assign evNow     = classifyPair(sampPrev, sampCurr);

  always_comb begin
    unique case (modeNow)
      MODE_TIMER: hit = 1'b1;
      MODE_RISE:  hit = (evNow == EV_RISE);
      MODE_FALL:  hit = (evNow == EV_FALL);
      MODE_BOTH:  hit = (evNow != EV_NONE);
      default:    hit = 1'b0;
    endcase
  end

  always_comb begin
    strobe        = '0;
    strobe.clr    = cntClr;
    strobe.incr   = cntEn && !cntClr && hit;
    strobe.reload = cfgWrEn && (cfgWrData[CFG_W-1:2] != curSel);
  end
endmodule

// File: rtl/edge_qual_timer.sv
module edge_qual_timer
  import eqt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CAP = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [((NUM_CAP > 1) ? $clog2(NUM_CAP) : 1)+1:0] cfgWrData,
  output logic [((NUM_CAP > 1) ? $clog2(NUM_CAP) : 1)+1:0] cfgRdData,
  input  logic                cntEn,
  input  logic                cntClr,
  input  logic [NUM_CAP-1:0]  capIn,
  output logic [CNT_W-1:0]    count
);
  localparam int SEL_W = (NUM_CAP > 1) ? $clog2(NUM_CAP) : 1;

  cntStrobe_t       strobe;
  logic [SEL_W-1:0] curSel;
  logic [SEL_W-1:0] reloadSel;
  logic             sampCurr;
  logic             sampPrev;

  eqt_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .cntEn    (cntEn),
    .cntClr   (cntClr),
    .sampCurr (sampCurr),
    .sampPrev (sampPrev),
    .cfgQ     (cfgRdData),
    .curSel   (curSel),
    .reloadSel(reloadSel),
    .strobe   (strobe)
  );

  eqt_datapath #(.CNT_W(CNT_W), .NUM_CAP(NUM_CAP), .SEL_W(SEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .capIn    (capIn),
    .curSel   (curSel),
    .reloadSel(reloadSel),
    .strobe   (strobe),
    .count    (count),
    .sampCurr (sampCurr),
    .sampPrev (sampPrev)
  );
endmodule

// File: rtl/eqt_checker.sv
module eqt_checker #(
  parameter int CNT_W = 16,
  parameter int CFG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [CFG_W-1:0] cfgWrData,
  input logic [CFG_W-1:0] cfgRdData,
  input logic             cntEn,
  input logic             cntClr,
  input logic [CNT_W-1:0] count
);
  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData == $past(cfgWrData)));

  // R3
  timer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !cntClr && cfgRdData[1:0] == 2'b00) |=> (count == CNT_W'($past(count) + 1'b1)));

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !cntClr) |=> $stable(count));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> (count == '0));

  // R12
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntClr |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));
endmodule

bind edge_qual_timer eqt_checker #(.CNT_W(CNT_W), .CFG_W(SEL_W + 2)) u_eqtChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgWrEn  (cfgWrEn),
  .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData),
  .cntEn    (cntEn),
  .cntClr   (cntClr),
  .count    (count)
);

// File: tb/test_edge_qual_timer.sv
`timescale 1ns/1ps
module test_edge_qual_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgWrData = '0;
  logic [3:0]  cfgRdData;
  logic        cntEn = 1'b0;
  logic        cntClr = 1'b0;
  logic [3:0]  capIn = '0;
  logic [15:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_qual_timer i_edge_qual_timer (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .cntEn    (cntEn),
    .cntClr   (cntClr),
    .capIn    (capIn),
    .count    (count)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] lane, input logic [1:0] mode);
    cfgWrData = {lane, mode};
    cfgWrEn = 1'b1;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic clearPulse();
    cntClr = 1'b1;
    tick(1);
    cntClr = 1'b0;
  endtask

  initial begin
    tick(2);
    chk("R1 count after reset", count, 0);
    chk("R1 cfg after reset", cfgRdData, 0);
    rstN = 1'b1;
    tick(1);

    // R2 write and read back
    cfgWrite(2'd2, 2'b11);
    chk("R2 readback", cfgRdData, 4'b1011);

    // R3 timer mode
    cfgWrite(2'd0, 2'b00);
    cntEn = 1'b1;
    clearPulse();
    tick(10);
    chk("R3 timer ten clocks", count, 10);

    // R4 R5 R6 R7 sweep over every lane and edge mode
    for (int lane = 0; lane < 4; lane++) begin
      for (int mode = 1; mode < 4; mode++) begin
        int other;
        int expc;
        other = (lane + 1) % 4;
        cfgWrite(lane[1:0], mode[1:0]);
        tick(4);
        clearPulse();
        for (int t = 1; t <= 6; t++) begin
          capIn[lane] = ~capIn[lane];
          tick(3);
          if (mode == 1) expc = (t + 1) / 2;
          else if (mode == 2) expc = t / 2;
          else expc = t;
          if (mode == 1) chk("R4 rising count (R12 step)", count, expc);
          else if (mode == 2) chk("R5 falling count (R12 step)", count, expc);
          else chk("R6 both-edge count (R12 step)", count, expc);
          tick(1);
          capIn[other] = ~capIn[other];
          tick(4);
          chk("R7 unselected lane ignored", count, expc);
        end
      end
    end

    // R8 disable holds and drops edges seen while off
    cfgWrite(2'd0, 2'b01);
    tick(4);
    clearPulse();
    cntEn = 1'b0;
    capIn[0] = 1'b1;
    tick(5);
    chk("R8 hold while disabled", count, 0);
    cntEn = 1'b1;
    tick(4);
    chk("R8 edge during disable not counted", count, 0);
    capIn[0] = 1'b0;
    tick(4);
    capIn[0] = 1'b1;
    tick(3);
    chk("R8 counts again when enabled", count, 1);

    // R9 clear while disabled, and pending edge dropped
    cntEn = 1'b0;
    clearPulse();
    chk("R9 clear while disabled", count, 0);
    cntEn = 1'b1;
    capIn[0] = 1'b0;
    tick(4);
    capIn[0] = 1'b1;
    tick(2);
    cntClr = 1'b1;
    tick(1);
    cntClr = 1'b0;
    chk("R9 clear wins over pending edge", count, 0);
    tick(4);
    chk("R9 pending edge discarded", count, 0);
    capIn[0] = 1'b0;
    tick(4);

    // R11 lane switch across different levels
    clearPulse();
    capIn[1] = 1'b1;
    tick(4);
    cfgWrite(2'd1, 2'b01);
    tick(4);
    chk("R11 switch to high lane no count", count, 0);
    cfgWrite(2'd0, 2'b11);
    tick(4);
    chk("R11 switch to low lane no count", count, 0);
    capIn[1] = 1'b0;
    tick(4);

    // R10 wrap
    cfgWrite(2'd0, 2'b00);
    clearPulse();
    tick(65535);
    chk("R10 reaches max", count, 16'hFFFF);
    tick(1);
    chk("R10 wraps to zero", count, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule